// File: doc/BRIEF.md
# Auto-Reloading Down-Counter with Shaped Terminal-Count Output

This block is a programmable down-counter that steps once per clock whenever its count-enable strobe and its gate are both high. When a step takes the count from one to terminal count, the counter reloads on its own from a holding register and keeps running. Software does not need to rewrite it. Every terminal-count event appears on a raw flag. The same event also drives one shaped output. A mode bit selects whether that output is a single-cycle pulse or a level that flips at each event. A polarity bit then selects true or inverted logic for it, so one count sequence can produce four output forms.

A write to the holding register has two behaviours. While the gate is low (counter stopped), the value is also copied into the active count. While the gate is high (counter running), only the holding register changes, and the new value takes effect at the next reload. A holding value of zero is treated as the full range of 2^W steps. All pins are plain control and status signals. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `reload_counter`

## Requirements
- R1: On each clock edge where `cnt_en` and `gate` are both high and the count is not 1, the count decreases by exactly one, wrapping modulo 2^W.
- R2: On a stepping edge while the count is 1, the count reloads from the holding register, and `tc_flag` is high for exactly the following clock cycle. With holding value N (1 ≤ N) and continuous stepping, `tc_flag` rises once every N cycles.
- R3: With `mode_toggle` = 0 (pulse form), `out_sig` equals `tc_flag` when `pol_inv` = 0, so it is high for one cycle per terminal count.
- R4: With `mode_toggle` = 1 (toggle form), the output level flips once in the cycle after each terminal count and holds between terminal counts.
- R5: With `pol_inv` = 1, `out_sig` is the inverse of the pulse or toggle level that `pol_inv` = 0 would give.
- R6: A write (`load_we` = 1) while `gate` is low sets both the holding register and the active count to `load_val` at that edge.
- R7: A write while `gate` is high changes only the holding register. The running count continues, and the new value is used from the next reload on.
- R8: A holding value of 0 gives 2^W steps between terminal counts. A step from count 0 goes to the all-ones value.
- R9: Synchronous reset (`rst` = 1) clears the count, the holding register, the toggle state and `tc_flag`, and `out_sig` shows `pol_inv` (the inactive level).
- R10: `cnt_en` high with `gate` low leaves the count unchanged, and no terminal count occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-enable strobe, one step per cycle while high |
| gate | input | 1 | Counting permitted while high; low means stopped |
| load_we | input | 1 | Holding register write strobe |
| load_val | input | W | Value written to the holding register |
| mode_toggle | input | 1 | 0 = pulse form, 1 = toggle form |
| pol_inv | input | 1 | 1 = inverted output logic |
| out_sig | output | 1 | Shaped terminal-count output |
| tc_flag | output | 1 | Raw terminal-count flag, one cycle per event |

## Verification
The bench measures the terminal-count spacing through the ports for short periods and for a zero load. A design that counted zero as an empty period would stall or fire at every step instead of after 65536 steps. A write made while the gate is high but no steps are taken must not disturb the pending count. A design that copied it into the count would give a first terminal count at the new spacing instead of the old one. Enable with the gate low must produce no event and must not shift the later spacing. All four mode and polarity combinations are compared with a toggle model kept in the bench, which exposes a polarity applied before the shaping or a toggle that does not survive between events.

// File: rtl/reload_counter_pkg.sv
package reload_counter_pkg;
  typedef enum logic {
    SHAPE_PULSE  = 1'b0,
    SHAPE_TOGGLE = 1'b1
  } shape_e;
endpackage

// File: rtl/reload_counter_core.sv
module reload_counter_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] hold_o,
  output logic         tc_hit
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, hold_q;
  logic         step;

  assign step   = cnt_en & gate;
  assign tc_hit = step & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      if (load_we) hold_q <= load_val;
      if (load_we && !gate) begin
        cnt_q <= load_val;
      end else if (tc_hit) begin
        cnt_q <= hold_q;  // old holding value if a write coincides
      end else if (step) begin
        cnt_q <= cnt_q - ONE;  // zero wraps to all ones
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/reload_counter_shape.sv
module reload_counter_shape
  import reload_counter_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tc_hit,
  input  logic mode_toggle,
  input  logic pol_inv,
  output logic tc_flag,
  output logic out_sig
);
  logic   tc_q, tog_q, shaped;
  shape_e form;

  assign form = shape_e'(mode_toggle);

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      tc_q  <= tc_hit;
      tog_q <= tog_q ^ tc_hit;
    end
  end

  always_comb begin
    unique case (form)
      SHAPE_TOGGLE: shaped = tog_q;
      default:      shaped = tc_q;
    endcase
  end

  assign tc_flag = tc_q;
  assign out_sig = shaped ^ pol_inv;
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         gate,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic         mode_toggle,
  input  logic         pol_inv,
  output logic         out_sig,
  output logic         tc_flag
);
  logic [W-1:0] cnt_val, hold_val;
  logic         tc_hit;

  reload_counter_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate),
    .load_we(load_we), .load_val(load_val),
    .cnt_o(cnt_val), .hold_o(hold_val), .tc_hit(tc_hit)
  );

  reload_counter_shape u_shape (
    .clk(clk), .rst(rst), .tc_hit(tc_hit),
    .mode_toggle(mode_toggle), .pol_inv(pol_inv),
    .tc_flag(tc_flag), .out_sig(out_sig)
  );
endmodule

// File: rtl/reload_counter_chk.sv
module reload_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         gate,
  input logic         load_we,
  input logic [W-1:0] load_val,
  input logic         mode_toggle,
  input logic         pol_inv,
  input logic         out_sig,
  input logic         tc_flag,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] hold_val
);
  logic up_q;
  always_ff @(posedge clk) up_q <= !rst;

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && gate && cnt_val != W'(1)) |=> cnt_val == W'($past(cnt_val) - W'(1)));

  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && gate && cnt_val == W'(1) && !load_we) |=> (tc_flag && cnt_val == $past(hold_val)));

  p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_toggle && !pol_inv) |-> out_sig == tc_flag);

  p_toggle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (up_q && mode_toggle && $stable(mode_toggle) && $stable(pol_inv) && !tc_flag) |-> $stable(out_sig));

  p_pol_r5: assert property (@(posedge clk) disable iff (rst)
    (!mode_toggle && pol_inv) |-> out_sig == !tc_flag);

  p_stopped_load_r6: assert property (@(posedge clk) disable iff (rst)
    (load_we && !gate) |=> (cnt_val == $past(load_val) && hold_val == $past(load_val)));

  p_run_load_r7: assert property (@(posedge clk) disable iff (rst)
    (load_we && gate && !cnt_en) |=> ($stable(cnt_val) && hold_val == $past(load_val)));

  p_zero_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && gate && cnt_val == '0) |=> cnt_val == '1);

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tc_flag && cnt_val == '0 && hold_val == '0 && (mode_toggle || out_sig == pol_inv)));

  p_gate_low_r10: assert property (@(posedge clk) disable iff (rst)
    (!gate && !load_we) |=> ($stable(cnt_val) && !tc_flag));
endmodule

bind reload_counter reload_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate), .load_we(load_we),
  .load_val(load_val), .mode_toggle(mode_toggle), .pol_inv(pol_inv),
  .out_sig(out_sig), .tc_flag(tc_flag), .cnt_val(cnt_val), .hold_val(hold_val)
);

// File: tb/test_reload_counter.sv
module test_reload_counter;
  localparam int  W      = 16;
  localparam time PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0, gate = 1'b0, load_we = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         mode_toggle = 1'b0, pol_inv = 1'b0;
  logic         out_sig, tc_flag;

  int  n_chk = 0, n_fail = 0;
  bit  exp_tog = 1'b0;
  bit  done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  reload_counter #(.W(W)) i_reload_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .gate(gate), .load_we(load_we),
    .load_val(load_val), .mode_toggle(mode_toggle), .pol_inv(pol_inv),
    .out_sig(out_sig), .tc_flag(tc_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reset, then check idle outputs (R9)
  task automatic do_reset(input bit tog, input bit pol);
    @(negedge clk);
    mode_toggle = tog; pol_inv = pol;
    rst = 1'b1; cnt_en = 1'b0; gate = 1'b0; load_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_tog = 1'b0;
    @(negedge clk);
    check(tc_flag == 1'b0, "R9 tc_flag after reset", tc_flag, 0);
    check(out_sig == pol, "R9 out_sig after reset", out_sig, pol);
  endtask

  task automatic load_stopped(input logic [W-1:0] v);
    load_we = 1'b1; load_val = v; gate = 1'b0;
    @(negedge clk);
    load_we = 1'b0;
  endtask

  // step n cycles; first event at sample first-1, then every per
  task automatic run(input int n, input int first, input int per, input string req);
    gate = 1'b1; cnt_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      bit exp_tc;
      bit exp_out;
      @(negedge clk);
      exp_tc  = (i >= first-1) && (((i - (first-1)) % per) == 0);
      if (exp_tc) exp_tog = !exp_tog;
      exp_out = (mode_toggle ? exp_tog : exp_tc) ^ pol_inv;
      check(tc_flag == exp_tc, {req, " tc_flag"}, tc_flag, exp_tc);
      check(out_sig == exp_out, {req, " out_sig"}, out_sig, exp_out);
    end
    gate = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic t_pulse();  // R1 R2 R3
    do_reset(1'b0, 1'b0);
    load_stopped(W'(3));
    run(9, 3, 3, "R2/R3 pulse period 3");
    do_reset(1'b0, 1'b0);
    load_stopped(W'(1));
    run(4, 1, 1, "R1 period 1");
  endtask

  task automatic t_toggle();  // R4
    do_reset(1'b1, 1'b0);
    load_stopped(W'(4));
    run(16, 4, 4, "R4 toggle");
  endtask

  task automatic t_polarity();  // R5
    do_reset(1'b0, 1'b1);
    load_stopped(W'(2));
    run(6, 2, 2, "R5 inverted pulse");
    do_reset(1'b1, 1'b1);
    load_stopped(W'(3));
    run(9, 3, 3, "R5 inverted toggle");
  endtask

  task automatic t_gate_low();  // R10 R6
    do_reset(1'b0, 1'b0);
    load_stopped(W'(5));
    load_stopped(W'(2));  // R6 second stopped write replaces count
    cnt_en = 1'b1; gate = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(tc_flag == 1'b0, "R10 no event with gate low", tc_flag, 0);
    end
    run(4, 2, 2, "R6/R10 count kept at 2");
  endtask

  task automatic t_load_running();  // R7
    do_reset(1'b0, 1'b0);
    load_stopped(W'(4));
    gate = 1'b1; cnt_en = 1'b0; load_we = 1'b1; load_val = W'(2);
    @(negedge clk);
    load_we = 1'b0;
    check(tc_flag == 1'b0, "R7 no event on running write", tc_flag, 0);
    run(8, 4, 2, "R7 new value after reload");
  endtask

  task automatic t_zero();  // R8
    do_reset(1'b0, 1'b0);
    load_stopped('0);
    run(65537, 65536, 65536, "R8 zero load");
  endtask

  task automatic t_reset_mid();  // R9
    do_reset(1'b1, 1'b0);
    load_stopped(W'(1));
    run(1, 1, 1, "R4 single toggle");
    check(out_sig == 1'b1, "R9 toggle set before reset", out_sig, 1);
    do_reset(1'b1, 1'b0);
    check(out_sig == 1'b0, "R9 toggle cleared", out_sig, 0);
  endtask

  initial begin
    t_pulse();
    t_toggle();
    t_polarity();
    t_gate_low();
    t_load_running();
    t_zero();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule